// File: doc/BRIEF.md
# Field-Synchronised Video Capture Sequencer

This block runs a small instruction program that steers captured video bytes into memory. It fetches each instruction as two 32-bit words from a program memory. It then either waits for the start of an odd or an even field, redirects its own fetch pointer, or moves a given number of incoming pixel bytes to consecutive memory addresses. Software prepares the program so that each scan line lands in a buffer that may be scattered across memory. A line can be split across several write instructions, and each continuation states where in the line it resumes.

The sequencer is started with a pulse and a starting program index. It packs bytes little-endian into 32-bit memory writes with per-byte enables and raises a one-cycle interrupt when a marked instruction completes. On a malformed instruction it stops fetching and sets a sticky error flag, which only reset clears.

Top module: `fieldDmaSeq`

## Requirements
- R1: A `start` pulse in the idle state begins fetching at word index `startPtr`. Each instruction is read as two words, first at index p and then at p+1, with `progData` returned one cycle after `progRd`. After a non-jump instruction, the next fetch starts at p+2.
- R2: An instruction is malformed when bit 31 of its first word is 0, or when its opcode (bits 30:28) is 0, 6 or 7. A malformed instruction sets `err`, which stays set until reset. After that the block issues no further program reads and takes no bytes.
- R3: Opcode 1 waits for a `fieldOdd` pulse and opcode 2 waits for a `fieldEven` pulse. A field pulse of the other kind is ignored. Neither opcode uses the second word.
- R4: Opcode 3 (jump) completes at once, and the next fetch starts at word index `word1[PTR_W+1:2]`, where the second word is a byte address.
- R5: Opcode 4 (line start) clears the per-line byte counter and takes no byte (`pixReady` low) until a `lineMark` pulse. It then writes `word0[11:0]` bytes to consecutive byte addresses starting at the second word.
- R6: Opcode 5 (continuation) writes `word0[11:0]` bytes starting at the second word, without waiting for a marker. Its position field `word0[23:12]` must equal the number of bytes written since the last line start. On a mismatch it writes nothing and sets `err`, as in R2.
- R7: The byte for address a goes to lane a[1:0] of the write at address a with bits 1:0 cleared. Lane k occupies `wrData[8k+7:8k]` and is enabled by `wrBe[k]`. A write is issued when lane 3 is filled or when an instruction's last byte is taken.
- R8: While `wrValid` is high and `wrReady` is low, `wrValid`, `wrAddr`, `wrData` and `wrBe` hold their values.
- R9: An instruction with bit 27 set produces exactly one single-cycle `irq` pulse after it completes. An instruction with bit 27 clear produces none.
- R10: A write instruction whose count is 0 completes without any memory write. A line start with count 0 still waits for its marker.
- R11: After reset, `wrValid`, `irq`, `err`, `progRd` and `pixReady` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, honoured while idle |
| startPtr | input | PTR_W | Word index of the first instruction |
| progRd | output | 1 | Program memory read strobe |
| progAddr | output | PTR_W | Program memory word index |
| progData | input | 32 | Program word, valid one cycle after the read |
| pixValid | input | 1 | Pixel byte present |
| pixData | input | 8 | Pixel byte |
| pixReady | output | 1 | Pixel byte is taken this cycle if valid |
| fieldOdd | input | 1 | Odd field start pulse |
| fieldEven | input | 1 | Even field start pulse |
| lineMark | input | 1 | Line start pulse |
| wrValid | output | 1 | Memory write request |
| wrReady | input | 1 | Memory write accepted |
| wrAddr | output | 32 | Word-aligned write byte address |
| wrData | output | 32 | Write data, little-endian lanes |
| wrBe | output | 4 | Per-byte write enables |
| irq | output | 1 | Completion interrupt pulse |
| err | output | 1 | Sticky error flag |

## Verification
The bench sends a line that begins three bytes into a word and continues through a second, unaligned instruction. A packer that mishandles lanes or fails to flush at an instruction's end would then produce wrong enables or lose bytes. It presents an even-field pulse while an odd wait is pending, and bytes before a line marker, so that a sequencer that releases early would finish too soon and raise its interrupt at the wrong time. It applies write back-pressure in the middle of a line, where a design that drops or changes a stalled word would corrupt the stored image. It also drives malformed words, a wrong continuation position, zero-count writes and a jump over a poisoned slot, where a design without halting or with a wrong pointer update would keep fetching or set the error flag.

// File: rtl/fds_pkg.sv
package fds_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int WORD_BYTES = 4;
  localparam int CNT_W      = 12;

  localparam logic [2:0] OP_SYNC_ODD   = 3'd1;
  localparam logic [2:0] OP_SYNC_EVEN  = 3'd2;
  localparam logic [2:0] OP_JUMP       = 3'd3;
  localparam logic [2:0] OP_LINE_START = 3'd4;
  localparam logic [2:0] OP_INLINE     = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH0, S_FETCH1, S_DECODE,
    S_WAIT_ODD, S_WAIT_EVEN, S_WAIT_LINE, S_MOVE, S_HALT
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadInstr;
    logic clearLine;
    logic moveEn;
  } dpCtrl_t;
endpackage

// File: rtl/fds_ctrl.sv
module fds_ctrl
  import fds_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [PTR_W-1:0]     startPtr,
  output logic                 progRd,
  output logic [PTR_W-1:0]     progAddr,
  input  logic [31:0]          progData,
  input  logic                 fieldOdd,
  input  logic                 fieldEven,
  input  logic                 lineMark,
  input  logic                 remZero,
  input  logic [CNT_W-1:0]     lineCount,
  output dpCtrl_t              ctl,
  output logic [31:0]          instrAddr,
  output logic [CNT_W-1:0]     instrCount,
  output logic                 irq,
  output logic                 err
);
  timeunit 1ns;
  timeprecision 100ps;

  seqState_e state, nextState;
  logic [PTR_W-1:0] ptr;
  logic             validReg, irqEnReg;
  logic [2:0]       opReg;
  logic [CNT_W-1:0] posReg, cntReg;
  logic             finish, goHalt, jumpTaken;
  logic             irqQ, errQ;

  assign instrAddr  = progData;
  assign instrCount = cntReg;
  assign irq        = irqQ;
  assign err        = errQ;

  always_comb begin
    nextState = state;
    progRd    = 1'b0;
    progAddr  = ptr;
    ctl       = '0;
    finish    = 1'b0;
    goHalt    = 1'b0;
    jumpTaken = 1'b0;
    unique case (state)
      S_IDLE:   if (start) nextState = S_FETCH0;
      S_FETCH0: begin progRd = 1'b1; nextState = S_FETCH1; end
      S_FETCH1: begin
        progRd    = 1'b1;
        progAddr  = ptr + PTR_W'(1);
        nextState = S_DECODE;
      end
      S_DECODE: begin
        if (!validReg) goHalt = 1'b1;
        else begin
          case (opReg)
            OP_SYNC_ODD:  nextState = S_WAIT_ODD;
            OP_SYNC_EVEN: nextState = S_WAIT_EVEN;
            OP_JUMP:      begin jumpTaken = 1'b1; finish = 1'b1; end
            OP_LINE_START: begin
              ctl.loadInstr = 1'b1;
              ctl.clearLine = 1'b1;
              nextState     = S_WAIT_LINE;
            end
            OP_INLINE: begin
              if (posReg != lineCount) goHalt = 1'b1;
              else begin
                ctl.loadInstr = 1'b1;
                nextState     = S_MOVE;
              end
            end
            default: goHalt = 1'b1;
          endcase
        end
      end
      S_WAIT_ODD:  if (fieldOdd)  finish = 1'b1;
      S_WAIT_EVEN: if (fieldEven) finish = 1'b1;
      S_WAIT_LINE: if (lineMark)  nextState = S_MOVE;
      S_MOVE: begin
        ctl.moveEn = 1'b1;
        if (remZero) finish = 1'b1;
      end
      S_HALT:  nextState = S_HALT;
      default: goHalt = 1'b1;
    endcase
    if (finish) nextState = S_FETCH0;
    if (goHalt) nextState = S_HALT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      ptr      <= '0;
      validReg <= 1'b0;
      irqEnReg <= 1'b0;
      opReg    <= '0;
      posReg   <= '0;
      cntReg   <= '0;
      irqQ     <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && start) ptr <= startPtr;
      else if (jumpTaken)           ptr <= progData[PTR_W+1:2];
      else if (finish)              ptr <= ptr + PTR_W'(2);
      if (state == S_FETCH1) begin
        validReg <= progData[31];
        opReg    <= progData[30:28];
        irqEnReg <= progData[27];
        posReg   <= progData[23:12];
        cntReg   <= progData[11:0];
      end
      irqQ <= finish & irqEnReg;
      errQ <= errQ | goHalt;
    end
  end

  // R2: error flag never clears on its own
  a_r2_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    err |=> err);
  // R2: a halted sequencer reads no program words
  a_r2_halt_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HALT) |-> (!progRd && err));
  // R1: second read of a pair addresses the following word
  a_r1_pair_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (progRd && $past(progRd)) |-> (progAddr == $past(progAddr) + PTR_W'(1)));
  // R4: a jump sends the next fetch to the target taken from the second word
  a_r4_jump_target: assert property (@(posedge clk) disable iff (!rstN)
    jumpTaken |=> (progRd && progAddr == $past(progData[PTR_W+1:2])));
  // R9: interrupt is a single-cycle pulse
  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
endmodule

// File: rtl/fds_dp.sv
module fds_dp
  import fds_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [31:0]      instrAddr,
  input  logic [CNT_W-1:0] instrCount,
  input  logic             pixValid,
  input  logic [7:0]       pixData,
  output logic             pixReady,
  input  logic             wrReady,
  output logic             wrValid,
  output logic [31:0]      wrAddr,
  output logic [31:0]      wrData,
  output logic [3:0]       wrBe,
  output logic             remZero,
  output logic [CNT_W-1:0] lineCount
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int LANES  = WORD_BYTES;
  localparam int LANE_W = $clog2(LANES);

  logic [31:0]        curAddr;
  logic [CNT_W-1:0]   remCnt, lineCnt;
  logic [31-LANE_W:0] accWordAddr;
  logic [LANES-1:0]   accBe, laneOneHot;
  logic [31:0]        accData;
  logic               outValid, slotFree, fire, accept, flush;
  logic [LANE_W-1:0]  lane;

  assign lane       = curAddr[LANE_W-1:0];
  assign laneOneHot = LANES'(1) << lane;
  assign remZero    = (remCnt == '0);
  assign slotFree   = !outValid || wrReady;
  assign fire       = outValid && wrReady;
  assign pixReady   = ctl.moveEn && !remZero && slotFree;
  assign accept     = pixReady && pixValid;
  assign flush      = accept && ((lane == LANE_W'(LANES-1)) || (remCnt == CNT_W'(1)));

  assign wrValid    = outValid;
  assign wrAddr     = {accWordAddr, {LANE_W{1'b0}}};
  assign wrData     = accData;
  assign wrBe       = accBe;
  assign lineCount  = lineCnt;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [7:0] laneByte;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                               laneByte <= '0;
      else if (accept && lane == LANE_W'(g))   laneByte <= pixData;
    end
    assign accData[8*g +: 8] = laneByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr     <= '0;
      remCnt      <= '0;
      lineCnt     <= '0;
      accWordAddr <= '0;
      accBe       <= '0;
      outValid    <= 1'b0;
    end else begin
      if (ctl.loadInstr) begin
        curAddr <= instrAddr;
        remCnt  <= instrCount;
      end else if (accept) begin
        curAddr <= curAddr + 32'd1;
        remCnt  <= remCnt - CNT_W'(1);
      end
      if (ctl.clearLine)  lineCnt <= '0;
      else if (accept)    lineCnt <= lineCnt + CNT_W'(1);
      if (accept) begin
        accWordAddr <= curAddr[31:LANE_W];
        accBe       <= (fire ? '0 : accBe) | laneOneHot;
      end else if (fire) begin
        accBe <= '0;
      end
      outValid <= accept ? flush : (outValid && !wrReady);
    end
  end

  // R8: a stalled write keeps every field
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr) && $stable(wrData) && $stable(wrBe)));
  // R7: every issued write enables at least one lane
  a_r7_be_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrBe != '0));
endmodule

// File: rtl/fieldDmaSeq.sv
module fieldDmaSeq
  import fds_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [PTR_W-1:0] startPtr,
  output logic             progRd,
  output logic [PTR_W-1:0] progAddr,
  input  logic [31:0]      progData,
  input  logic             pixValid,
  input  logic [7:0]       pixData,
  output logic             pixReady,
  input  logic             fieldOdd,
  input  logic             fieldEven,
  input  logic             lineMark,
  output logic             wrValid,
  input  logic             wrReady,
  output logic [31:0]      wrAddr,
  output logic [31:0]      wrData,
  output logic [3:0]       wrBe,
  output logic             irq,
  output logic             err
);
  timeunit 1ns;
  timeprecision 100ps;

  dpCtrl_t          ctl;
  logic [31:0]      instrAddr;
  logic [CNT_W-1:0] instrCount, lineCount;
  logic             remZero;

  fds_ctrl #(.PTR_W(PTR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .startPtr(startPtr),
    .progRd(progRd), .progAddr(progAddr), .progData(progData),
    .fieldOdd(fieldOdd), .fieldEven(fieldEven), .lineMark(lineMark),
    .remZero(remZero), .lineCount(lineCount), .ctl(ctl),
    .instrAddr(instrAddr), .instrCount(instrCount), .irq(irq), .err(err)
  );

  fds_dp uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .instrAddr(instrAddr),
    .instrCount(instrCount), .pixValid(pixValid), .pixData(pixData),
    .pixReady(pixReady), .wrReady(wrReady), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .wrBe(wrBe),
    .remZero(remZero), .lineCount(lineCount)
  );
endmodule

// File: tb/sim_fieldDmaSeq.sv
module sim_fieldDmaSeq;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int PTR_W = 8;

  logic clk = 1'b0;
  logic rstN, start, pixValid, fieldOdd, fieldEven, lineMark, wrReady;
  logic [PTR_W-1:0] startPtr;
  logic [31:0] progData;
  logic [7:0]  pixData;
  logic progRd, pixReady, wrValid, irq, err;
  logic [PTR_W-1:0] progAddr;
  logic [31:0] wrAddr, wrData;
  logic [3:0]  wrBe;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  fieldDmaSeq #(.PTR_W(PTR_W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .startPtr(startPtr),
    .progRd(progRd), .progAddr(progAddr), .progData(progData),
    .pixValid(pixValid), .pixData(pixData), .pixReady(pixReady),
    .fieldOdd(fieldOdd), .fieldEven(fieldEven), .lineMark(lineMark),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr),
    .wrData(wrData), .wrBe(wrBe), .irq(irq), .err(err)
  );

  // program memory, one-cycle read latency
  logic [31:0] progMem [0:255];
  always @(posedge clk) if (progRd) progData <= progMem[progAddr];

  // observed memory image and write log
  logic [7:0]  img  [0:1023];
  logic        imgW [0:1023];
  logic [31:0] logAddr [0:63];
  logic [3:0]  logBe   [0:63];
  int wrCount, irqCnt, rdCnt, stallSeen;
  logic [PTR_W-1:0] firstRd;
  logic prevStall;
  logic [31:0] prevAddr, prevData;
  logic [3:0]  prevBe;
  logic bpOn = 1'b0;
  int   bpCnt = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: sampled between the drive point and the next rising edge
  always begin
    @(negedge clk);
    #2;
    if (rstN) begin
      if (prevStall) begin
        total++;
        if (!(wrValid && wrAddr == prevAddr && wrData == prevData && wrBe == prevBe)) begin
          bad++;
          $display("FAIL R8 actual=%0h expected=%0h", wrAddr, prevAddr);
        end
      end
      prevStall = wrValid && !wrReady;
      if (prevStall) stallSeen++;
      prevAddr = wrAddr; prevData = wrData; prevBe = wrBe;
      if (wrValid && wrReady) begin
        for (int k = 0; k < 4; k++)
          if (wrBe[k]) begin
            img[(wrAddr + k) & 1023]  = wrData[8*k +: 8];
            imgW[(wrAddr + k) & 1023] = 1'b1;
          end
        if (wrCount < 64) begin logAddr[wrCount] = wrAddr; logBe[wrCount] = wrBe; end
        wrCount++;
      end
      if (irq) irqCnt++;
      if (progRd) begin
        if (rdCnt == 0) firstRd = progAddr;
        rdCnt++;
      end
    end
  end

  // back-pressure pattern on the write port
  always @(negedge clk) begin
    bpCnt <= bpCnt + 1;
    if (bpOn) wrReady <= (bpCnt % 3 == 0);
  end

  function automatic logic [31:0] mk(input logic [2:0] op, input logic ie,
                                     input logic [11:0] pos, input logic [11:0] cnt);
    return {1'b1, op, ie, 3'b000, pos, cnt};
  endfunction

  task automatic resetDut();
    rstN = 1'b0; start = 1'b0; startPtr = '0; pixValid = 1'b0; pixData = '0;
    fieldOdd = 1'b0; fieldEven = 1'b0; lineMark = 1'b0; wrReady = 1'b1; bpOn = 1'b0;
    for (int i = 0; i < 256; i++) progMem[i] = 32'h0;
    for (int i = 0; i < 1024; i++) begin img[i] = 8'h0; imgW[i] = 1'b0; end
    wrCount = 0; irqCnt = 0; rdCnt = 0; stallSeen = 0; firstRd = '0; prevStall = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(input logic [PTR_W-1:0] p);
    @(negedge clk); start = 1'b1; startPtr = p;
    @(negedge clk); start = 1'b0;
    idle(8);
  endtask

  task automatic pulseOdd();  @(negedge clk); fieldOdd  = 1'b1; @(negedge clk); fieldOdd  = 1'b0; idle(8); endtask
  task automatic pulseEven(); @(negedge clk); fieldEven = 1'b1; @(negedge clk); fieldEven = 1'b0; idle(8); endtask
  task automatic pulseLine(); @(negedge clk); lineMark  = 1'b1; @(negedge clk); lineMark  = 1'b0; endtask

  task automatic sendBytes(input int n, input logic [7:0] base, input string req);
    for (int i = 0; i < n; i++) begin
      int guard = 0;
      @(negedge clk);
      pixValid = 1'b1; pixData = base + 8'(i);
      #1;
      while (!pixReady && guard < 200) begin @(negedge clk); #1; guard++; end
      if (guard >= 200) begin
        total++; bad++;
        $display("FAIL %s actual=%0d expected=%0d (byte not taken)", req, i, n);
        break;
      end
    end
    @(negedge clk); pixValid = 1'b0;
    idle(10);
  endtask

  task automatic chkBytes(input int addr, input int n, input logic [7:0] base, input string req);
    for (int i = 0; i < n; i++) begin
      chk(req, {imgW[(addr + i) & 1023], 23'h0, img[(addr + i) & 1023]}, {1'b1, 23'h0, base + 8'(i)});
    end
  endtask

  task automatic testReset();
    resetDut();
    chk("R11 wrValid", {31'h0, wrValid}, 32'h0);
    chk("R11 irq",     {31'h0, irq},     32'h0);
    chk("R11 err",     {31'h0, err},     32'h0);
    chk("R11 progRd",  {31'h0, progRd},  32'h0);
    chk("R11 pixReady",{31'h0, pixReady},32'h0);
  endtask

  task automatic testBasic();
    resetDut();
    progMem[4] = mk(OP_ODD, 1'b1, 12'h0, 12'h0);
    progMem[6] = mk(OP_LS, 1'b1, 12'h0, 12'd8); progMem[7] = 32'h100;
    progMem[8] = mk(OP_EVEN, 1'b0, 12'h0, 12'h0);
    go(8'd4);
    chk("R1 first read index", {24'h0, firstRd}, 32'd4);
    chk("R1 two reads per instruction", rdCnt, 32'd2);
    pulseEven();
    chk("R3 wrong field ignored", irqCnt, 32'd0);
    pulseOdd();
    chk("R3 odd wait released", irqCnt, 32'd1);
    chk("R5 no byte before marker", {31'h0, pixReady}, 32'h0);
    pulseLine();
    sendBytes(8, 8'h10, "R5");
    chkBytes(32'h100, 8, 8'h10, "R5 line bytes");
    chk("R7 aligned write count", wrCount, 32'd2);
    chk("R9 irq count", irqCnt, 32'd2);
    chk("R1 next pair fetched", rdCnt, 32'd6);
  endtask

  localparam logic [2:0] OP_ODD = 3'd1, OP_EVEN = 3'd2, OP_JMP = 3'd3, OP_LS = 3'd4, OP_IN = 3'd5;

  task automatic testSplit();
    resetDut();
    progMem[0] = mk(OP_LS, 1'b0, 12'd0, 12'd3); progMem[1] = 32'h203;
    progMem[2] = mk(OP_IN, 1'b0, 12'd3, 12'd6); progMem[3] = 32'h301;
    progMem[4] = mk(OP_ODD, 1'b0, 12'd0, 12'd0);
    go(8'd0);
    pulseLine();
    sendBytes(9, 8'h40, "R6");
    chkBytes(32'h203, 3, 8'h40, "R6 head bytes");
    chkBytes(32'h301, 6, 8'h43, "R6 continuation bytes");
    chk("R6 no error", {31'h0, err}, 32'h0);
    chk("R7 write count", wrCount, 32'd4);
    chk("R7 w0 addr", logAddr[0], 32'h200); chk("R7 w0 be", {28'h0, logBe[0]}, 32'h8);
    chk("R7 w1 addr", logAddr[1], 32'h204); chk("R7 w1 be", {28'h0, logBe[1]}, 32'h3);
    chk("R7 w2 addr", logAddr[2], 32'h300); chk("R7 w2 be", {28'h0, logBe[2]}, 32'he);
    chk("R7 w3 addr", logAddr[3], 32'h304); chk("R7 w3 be", {28'h0, logBe[3]}, 32'h7);
    chk("R9 no irq when bit clear", irqCnt, 32'd0);
  endtask

  task automatic testJump();
    resetDut();
    progMem[0]  = mk(OP_JMP, 1'b1, 12'd0, 12'd0); progMem[1] = 32'h40;
    progMem[2]  = 32'h0;
    progMem[16] = mk(OP_LS, 1'b0, 12'd0, 12'd2); progMem[17] = 32'h80;
    progMem[18] = mk(OP_ODD, 1'b0, 12'd0, 12'd0);
    go(8'd0);
    chk("R4 no error after jump", {31'h0, err}, 32'h0);
    chk("R9 jump irq", irqCnt, 32'd1);
    pulseLine();
    sendBytes(2, 8'h77, "R4");
    chkBytes(32'h80, 2, 8'h77, "R4 target executed");
  endtask

  task automatic testInvalid(input logic [31:0] word, input string req);
    int rdBefore;
    resetDut();
    progMem[0] = word; progMem[1] = 32'h10;
    progMem[2] = mk(OP_LS, 1'b0, 12'd0, 12'd4); progMem[3] = 32'h20;
    go(8'd0);
    chk(req, {31'h0, err}, 32'h1);
    rdBefore = rdCnt;
    pulseLine();
    idle(10);
    chk({req, " reads stop"}, rdCnt, rdBefore);
    chk({req, " no byte taken"}, {31'h0, pixReady}, 32'h0);
    chk({req, " no writes"}, wrCount, 32'd0);
    chk("R2 error sticky", {31'h0, err}, 32'h1);
  endtask

  task automatic testMismatch();
    resetDut();
    progMem[0] = mk(OP_LS, 1'b0, 12'd0, 12'd4); progMem[1] = 32'h10;
    progMem[2] = mk(OP_IN, 1'b0, 12'd5, 12'd2); progMem[3] = 32'h20;
    go(8'd0);
    pulseLine();
    sendBytes(4, 8'h30, "R6 mismatch head");
    chk("R6 mismatch error", {31'h0, err}, 32'h1);
    chk("R6 mismatch writes", wrCount, 32'd1);
    chk("R6 nothing at continuation", {31'h0, imgW[32'h20]}, 32'h0);
  endtask

  task automatic testBackPressure();
    resetDut();
    progMem[0] = mk(OP_LS, 1'b1, 12'd0, 12'd10); progMem[1] = 32'h401;
    progMem[2] = mk(OP_ODD, 1'b0, 12'd0, 12'd0);
    go(8'd0);
    bpOn = 1'b1;
    pulseLine();
    sendBytes(10, 8'hA0, "R8");
    bpOn = 1'b0;
    @(negedge clk); wrReady = 1'b1;
    idle(6);
    chkBytes(32'h401, 10, 8'hA0, "R8 bytes under stall");
    chk("R8 stall exercised", {31'h0, stallSeen > 0}, 32'h1);
    chk("R7 stalled write count", wrCount, 32'd3);
    chk("R7 last be", {28'h0, logBe[2]}, 32'h7);
    chk("R9 irq once", irqCnt, 32'd1);
  endtask

  task automatic testZeroCount();
    resetDut();
    progMem[0] = mk(OP_LS, 1'b1, 12'd0, 12'd0); progMem[1] = 32'h50;
    progMem[2] = mk(OP_IN, 1'b1, 12'd0, 12'd0); progMem[3] = 32'h58;
    progMem[4] = mk(OP_LS, 1'b0, 12'd0, 12'd1); progMem[5] = 32'h60;
    progMem[6] = mk(OP_ODD, 1'b0, 12'd0, 12'd0);
    go(8'd0);
    chk("R10 zero line start waits", irqCnt, 32'd0);
    pulseLine();
    idle(10);
    chk("R10 zero count completes", irqCnt, 32'd2);
    chk("R10 zero count writes nothing", wrCount, 32'd0);
    pulseLine();
    sendBytes(1, 8'h5A, "R10");
    chkBytes(32'h60, 1, 8'h5A, "R10 following instruction");
    chk("R10 single write", wrCount, 32'd1);
    chk("R9 bit clear no irq", irqCnt, 32'd2);
  endtask

  initial begin
    testReset();
    testBasic();
    testSplit();
    testJump();
    testInvalid(32'h4000_0004, "R2 top bit clear");
    testInvalid({1'b1, 3'd7, 28'h0000_004}, "R2 opcode 7");
    testInvalid({1'b1, 3'd0, 28'h0000_004}, "R2 opcode 0");
    testMismatch();
    testBackPressure();
    testZeroCount();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #750000;
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule